// File: doc/BRIEF.md
# Real-Time Periodic Wakeup Interrupt

This block raises a periodic interrupt from a slow timebase. One control register selects the timebase and the period and holds the status flag. The timebase is either an always-running low-frequency internal tick or an optional faster reference tick. The period is a power-of-two number of source ticks, chosen by a 3-bit code. Code zero turns the block off. When a period has elapsed, a sticky flag is set. The interrupt output follows that flag while the local enable is on.

Both timebases arrive as single-cycle tick strobes in the system clock domain. The oscillators that produce them are outside this block. A power-mode input tells the block which low-power state the system is in. The block uses it to refuse reference ticks whenever that clock may not wake the system.

Software acknowledges an event by writing 1 to a self-clearing bit. The flag itself cannot be written directly. Changing the period or the source restarts the count from zero.

Top module: `rti_wakeup`

## Requirements
- R1: After reset the control register reads 8'h00 and irq is 0.
- R2: Register layout: bits [2:0] period code, bit 3 source (0 internal tick, 1 reference tick), bit 4 interrupt enable, bit 5 acknowledge, bit 6 reads 0, bit 7 flag. For code c the flag sets on the Nth accepted tick after a restart, and not earlier. N is 8 for c=1 and 2^(c+3) for c=2..7, giving 32, 64, 128, 256, 512 and 1024.
- R3: With code 000 the count is held at zero and the flag never sets, whatever ticks arrive.
- R4: Writing 1 to bit 7 has no effect. The only way to clear the flag is a write with bit 5 set. Bit 5 always reads 0.
- R5: irq is the flag ANDed with bit 4. Clearing bit 4 masks irq but does not stop the flag from setting.
- R6: Only ticks on the selected source are counted. Ticks on the other source are ignored.
- R7: pwr_mode encodes 0 run, 1 wait, 2 light stop and 3 deep stop. Internal ticks count in every mode. Reference ticks count in run and wait. In light stop they count only while ref_stop_en and ref_low_range are both 1.
- R8: In deep stop (pwr_mode 3), reference ticks are never counted. Only the internal source can set the flag.
- R9: A write that changes the period code or the source bit restarts the count from zero, so the next full period follows.
- R10: The flag stays set across further periods, with no event counting. If an acknowledge and an elapsing tick fall in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write data |
| rd_data | output | 8 | Control register read value |
| lpo_tick | input | 1 | Internal low-frequency tick strobe |
| ref_tick | input | 1 | Reference clock tick strobe |
| ref_stop_en | input | 1 | Reference clock kept running in stop |
| ref_low_range | input | 1 | Reference clock in low-frequency range |
| pwr_mode | input | 2 | Power state: 0 run, 1 wait, 2 light stop, 3 deep stop |
| irq | output | 1 | Interrupt request |

## Verification
A corrupted prescaler count shows at the ports as a flag that rises too early or too late. The error appears at the first terminal tick after the fault, which can be up to a full period later (1024 ticks for the longest code). A missing restart on a configuration write shows within the first period after the write. A wrong qualification of the reference clock shows as a flag set in deep stop, or in light stop with the clock not kept running. A broken flag-update priority shows in the very cycle where an acknowledge meets an elapsing tick.

// File: rtl/rti_pkg.sv
package rti_pkg;
  localparam int CODE_W   = 3;
  localparam int CTRL_W   = 8;
  localparam int SRC_BIT  = 3;
  localparam int IE_BIT   = 4;
  localparam int ACK_BIT  = 5;
  localparam int FLAG_BIT = 7;

  typedef enum logic [1:0] {
    PM_RUN        = 2'd0,
    PM_WAIT       = 2'd1,
    PM_STOP_LIGHT = 2'd2,
    PM_STOP_DEEP  = 2'd3
  } pwr_mode_e;

  typedef struct packed {
    logic              ie;
    logic              src;
    logic [CODE_W-1:0] code;
  } ctrl_t;
endpackage

// File: rtl/rti_tick_gate.sv
module rti_tick_gate
  import rti_pkg::*;
#(
  parameter bit HAS_REF = 1'b1
) (
  input  logic      lpo_tick,
  input  logic      ref_tick,
  input  logic      src_sel,
  input  pwr_mode_e mode,
  input  logic      ref_stop_en,
  input  logic      ref_low_range,
  output logic      tick
);
  logic ref_ok;

  generate
    if (HAS_REF) begin : g_ref
      always_comb begin
        unique case (mode)
          PM_RUN, PM_WAIT: ref_ok = ref_tick;
          PM_STOP_LIGHT:   ref_ok = ref_tick & ref_stop_en & ref_low_range;
          default:         ref_ok = 1'b0;
        endcase
      end
    end else begin : g_noref
      logic unused_ref_in;
      assign unused_ref_in = ref_tick ^ ref_stop_en ^ ref_low_range ^ (^mode);
      assign ref_ok = 1'b0;
    end
  endgenerate

  assign tick = src_sel ? ref_ok : lpo_tick;
endmodule

// File: rtl/rti_prescaler.sv
module rti_prescaler
  import rti_pkg::*;
#(
  parameter int FIRST_LOG2  = 3,
  parameter int LOG2_OFFSET = 3,
  parameter int CNT_W       = LOG2_OFFSET + (1 << CODE_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [CODE_W-1:0] code,
  input  logic              restart,
  output logic              done
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             active;
  logic             at_last;

  function automatic logic [CNT_W-1:0] last_count(input logic [CODE_W-1:0] c);
    int l;
    l = (c == CODE_W'(1)) ? FIRST_LOG2 : int'(c) + LOG2_OFFSET;
    return CNT_W'((1 << l) - 1);
  endfunction

  assign active  = (code != '0);
  assign at_last = (cnt_q == last_count(code));

  always_comb begin
    cnt_d = cnt_q;
    done  = 1'b0;
    if (restart || !active) begin
      cnt_d = '0;
    end else if (tick) begin
      if (at_last) begin
        cnt_d = '0;
        done  = 1'b1;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rti_ctrl_regs.sv
module rti_ctrl_regs
  import rti_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              period_done,
  output ctrl_t             ctrl,
  output logic              restart,
  output logic [CTRL_W-1:0] rd_data,
  output logic              irq
);
  ctrl_t ctrl_q, ctrl_d;
  logic  flag_q, flag_d;
  logic  ack;
  logic  unused_wr_bits;

  assign unused_wr_bits = wr_data[6] ^ wr_data[FLAG_BIT];

  assign ack     = wr_en & wr_data[ACK_BIT];
  assign restart = wr_en & ((wr_data[CODE_W-1:0] != ctrl_q.code) |
                            (wr_data[SRC_BIT] != ctrl_q.src));

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en) begin
      ctrl_d.code = wr_data[CODE_W-1:0];
      ctrl_d.src  = wr_data[SRC_BIT];
      ctrl_d.ie   = wr_data[IE_BIT];
    end
  end

  always_comb begin
    if (period_done)  flag_d = 1'b1;
    else if (ack)     flag_d = 1'b0;
    else              flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      flag_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      flag_q <= flag_d;
    end
  end

  always_comb begin
    rd_data                 = '0;
    rd_data[CODE_W-1:0]     = ctrl_q.code;
    rd_data[SRC_BIT]        = ctrl_q.src;
    rd_data[IE_BIT]         = ctrl_q.ie;
    rd_data[FLAG_BIT]       = flag_q;
  end

  assign ctrl = ctrl_q;
  assign irq  = flag_q & ctrl_q.ie;
endmodule

// File: rtl/rti_wakeup.sv
module rti_wakeup
  import rti_pkg::*;
#(
  parameter int FIRST_LOG2  = 3,
  parameter int LOG2_OFFSET = 3,
  parameter bit HAS_REF     = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       lpo_tick,
  input  logic       ref_tick,
  input  logic       ref_stop_en,
  input  logic       ref_low_range,
  input  logic [1:0] pwr_mode,
  output logic       irq
);
  localparam int CNT_W = LOG2_OFFSET + (1 << CODE_W) - 1;

  logic  rst_meta_q, rst_sync_q;
  ctrl_t ctrl;
  logic  restart;
  logic  tick;
  logic  period_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  rti_tick_gate #(.HAS_REF(HAS_REF)) u_gate (
    .lpo_tick      (lpo_tick),
    .ref_tick      (ref_tick),
    .src_sel       (ctrl.src),
    .mode          (pwr_mode_e'(pwr_mode)),
    .ref_stop_en   (ref_stop_en),
    .ref_low_range (ref_low_range),
    .tick          (tick)
  );

  rti_prescaler #(
    .FIRST_LOG2  (FIRST_LOG2),
    .LOG2_OFFSET (LOG2_OFFSET),
    .CNT_W       (CNT_W)
  ) u_prescale (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .tick    (tick),
    .code    (ctrl.code),
    .restart (restart),
    .done    (period_done)
  );

  rti_ctrl_regs u_regs (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .period_done (period_done),
    .ctrl        (ctrl),
    .restart     (restart),
    .rd_data     (rd_data),
    .irq         (irq)
  );
endmodule

// File: rtl/rti_wakeup_chk.sv
module rti_wakeup_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       ack_wr,
  input logic [7:0] rd_data,
  input logic [1:0] pwr_mode,
  input logic       irq,
  input logic       period_done
);
  a_r4_wo_bits_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[6:5] == 2'b00);

  a_r5_mask_blocks_irq: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[4] |-> !irq);

  a_r5_enabled_flag_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[4] && rd_data[7]) |-> irq);

  a_r3_off_never_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[2:0] == 3'd0 && !rd_data[7]) |=> !rd_data[7]);

  a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[7] && !(wr_en && ack_wr)) |=> rd_data[7]);

  a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ack_wr && !period_done) |=> !rd_data[7]);

  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    period_done |=> rd_data[7]);

  a_r8_deep_stop_ref_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode == 2'd3 && rd_data[3] && !rd_data[7] && !wr_en) |=> !rd_data[7]);
endmodule

bind rti_wakeup rti_wakeup_chk i_rti_wakeup_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .ack_wr      (wr_data[5]),
  .rd_data     (rd_data),
  .pwr_mode    (pwr_mode),
  .irq         (irq),
  .period_done (period_done)
);

// File: tb/test_rti_wakeup.sv
module test_rti_wakeup;
  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic       lpo_tick;
  logic       ref_tick;
  logic       ref_stop_en;
  logic       ref_low_range;
  logic [1:0] pwr_mode;
  logic       irq;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 0;

  rti_wakeup i_rti_wakeup (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wr_data       (wr_data),
    .rd_data       (rd_data),
    .lpo_tick      (lpo_tick),
    .ref_tick      (ref_tick),
    .ref_stop_en   (ref_stop_en),
    .ref_low_range (ref_low_range),
    .pwr_mode      (pwr_mode),
    .irq           (irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct packed {
    logic        src;
    logic [2:0]  code;
    logic [1:0]  mode;
    logic        sen;
    logic        lr;
    logic        line;
    logic [10:0] n;
    logic        exp;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 3'd1, 2'd0, 1'b0, 1'b0, 1'b0, 11'd8,    1'b1},
    '{1'b0, 3'd2, 2'd0, 1'b0, 1'b0, 1'b0, 11'd32,   1'b1},
    '{1'b0, 3'd3, 2'd1, 1'b0, 1'b0, 1'b0, 11'd64,   1'b1},
    '{1'b0, 3'd4, 2'd3, 1'b0, 1'b0, 1'b0, 11'd128,  1'b1},
    '{1'b0, 3'd5, 2'd0, 1'b0, 1'b0, 1'b0, 11'd256,  1'b1},
    '{1'b0, 3'd6, 2'd2, 1'b0, 1'b0, 1'b0, 11'd512,  1'b1},
    '{1'b0, 3'd7, 2'd0, 1'b0, 1'b0, 1'b0, 11'd1024, 1'b1},
    '{1'b1, 3'd1, 2'd0, 1'b0, 1'b0, 1'b1, 11'd8,    1'b1},
    '{1'b1, 3'd2, 2'd1, 1'b0, 1'b0, 1'b1, 11'd32,   1'b1},
    '{1'b1, 3'd3, 2'd2, 1'b1, 1'b1, 1'b1, 11'd64,   1'b1},
    '{1'b1, 3'd3, 2'd2, 1'b0, 1'b1, 1'b1, 11'd64,   1'b0},
    '{1'b1, 3'd3, 2'd2, 1'b1, 1'b0, 1'b1, 11'd64,   1'b0},
    '{1'b1, 3'd2, 2'd3, 1'b1, 1'b1, 1'b1, 11'd32,   1'b0},
    '{1'b0, 3'd0, 2'd0, 1'b0, 1'b0, 1'b0, 11'd1024, 1'b0},
    '{1'b0, 3'd1, 2'd0, 1'b0, 1'b0, 1'b1, 11'd8,    1'b0},
    '{1'b1, 3'd1, 2'd0, 1'b1, 1'b1, 1'b0, 11'd8,    1'b0}
  };

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %0h exp %0h", tag, got, exp);
    end
  endtask

  task automatic write_reg(input logic [7:0] v);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = v;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic ticks(input logic line, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (line) ref_tick = 1'b1;
      else      lpo_tick = 1'b1;
    end
    @(negedge clk);
    lpo_tick = 1'b0;
    ref_tick = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0;
    lpo_tick = 1'b0; ref_tick = 1'b0;
    ref_stop_en = 1'b0; ref_low_range = 1'b0; pwr_mode = 2'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    check("R1 reset rd_data", rd_data, 8'h00);
    check("R1 reset irq", {7'd0, irq}, 8'h00);

    for (int v = 0; v < NV; v++) begin
      write_reg(8'h20);
      pwr_mode      = VEC[v].mode;
      ref_stop_en   = VEC[v].sen;
      ref_low_range = VEC[v].lr;
      write_reg({3'b000, 1'b1, VEC[v].src, VEC[v].code});
      ticks(VEC[v].line, int'(VEC[v].n) - 1);
      check($sformatf("R2 R6 R7 R8 vec%0d early flag", v), {7'd0, rd_data[7]}, 8'h00);
      ticks(VEC[v].line, 1);
      check($sformatf("R2 R3 R6 R7 R8 vec%0d flag", v), {7'd0, rd_data[7]}, {7'd0, VEC[v].exp});
      check($sformatf("R5 vec%0d irq", v), {7'd0, irq}, {7'd0, VEC[v].exp});
      pwr_mode = 2'd0; ref_stop_en = 1'b0; ref_low_range = 1'b0;
    end

    // R4: flag bit not writable
    write_reg(8'h20);
    write_reg(8'h80);
    check("R4 write flag ignored", rd_data, 8'h00);

    // R5: mask irq, flag still sets
    write_reg(8'h01);
    ticks(1'b0, 8);
    check("R5 flag with ie=0", {7'd0, rd_data[7]}, 8'h01);
    check("R5 irq masked", {7'd0, irq}, 8'h00);
    write_reg(8'h11);
    check("R5 irq after enable", {7'd0, irq}, 8'h01);

    // R4: acknowledge clears, reads zero
    write_reg(8'h31);
    check("R4 ack clears flag, bit5 reads 0", rd_data, 8'h11);

    // R10: sticky across periods, single ack clears
    ticks(1'b0, 8);
    check("R10 flag set", {7'd0, rd_data[7]}, 8'h01);
    ticks(1'b0, 8);
    check("R10 flag held", {7'd0, rd_data[7]}, 8'h01);
    write_reg(8'h31);
    check("R10 single ack clears", {7'd0, rd_data[7]}, 8'h00);

    // R10: set wins over simultaneous ack
    ticks(1'b0, 7);
    @(negedge clk);
    lpo_tick = 1'b1; wr_en = 1'b1; wr_data = 8'h31;
    @(negedge clk);
    lpo_tick = 1'b0; wr_en = 1'b0;
    check("R10 set beats ack", {7'd0, rd_data[7]}, 8'h01);

    // R9: period change restarts count
    write_reg(8'h31);
    ticks(1'b0, 5);
    write_reg(8'h32);
    ticks(1'b0, 31);
    check("R9 code change no early flag", {7'd0, rd_data[7]}, 8'h00);
    ticks(1'b0, 1);
    check("R9 code change full period", {7'd0, rd_data[7]}, 8'h01);

    // R9: source change restarts count
    write_reg(8'h31);
    ticks(1'b0, 5);
    write_reg(8'h39);
    ticks(1'b1, 7);
    check("R9 source change no early flag", {7'd0, rd_data[7]}, 8'h00);
    ticks(1'b1, 1);
    check("R9 source change full period", {7'd0, rd_data[7]}, 8'h01);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule